// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block moves outgoing packets from host memory to a byte-stream output. Software places 16-byte descriptors in a circular ring in memory. Each descriptor names a packet buffer and gives its length. Software then programs the ring location, the ring size and a tail index through a small register port. The engine owns the head index. It advances the head across every descriptor that software has handed over. For each descriptor it reads the buffer bytes through a byte-wide memory port and streams them out with a last-byte marker.

Software can ask for completion reports. The engine marks finished descriptors as done by writing their status byte back to memory. These write-backs are either per descriptor or for every descriptor, and they can be held back until a batch has built up. Two sticky cause bits tell software when a write-back has happened and when the ring has run dry. Reading the cause register clears both bits.

Top module: `tx_ring_engine`

## Requirements
- R1: After reset the head, tail and cause registers read 0, the ring-size register reads 128, and `tx_valid` and `mem_req` are low. A read (`reg_rd`) returns its data on `reg_rdata` in the cycle after the request. The word addresses are: 0 ring base low, 1 ring base high, 2 ring size in bytes, 3 head (read-only), 4 tail, 5 transmit control, 6 descriptor control, 7 cause.
- R2: A write to the ring size keeps only whole 128-byte units. A value below 128 becomes 128, and a value above 16×MAX_DESC becomes 16×MAX_DESC.
- R3: A descriptor is fetched only while transmit control bit 0 is set and head differs from tail. The fetch reads bytes 0 to 11 at base + 16×head. While a request is not yet acknowledged, its address and direction stay stable.
- R4: The descriptor carries the buffer address in bytes 0–7 and the byte count in bytes 8–9, both little-endian, and the command in byte 11. The full 64-bit base and buffer addresses are used, including the high 32 bits.
- R5: Buffer bytes leave the block in address order, one per `tx_valid`/`tx_ready` handshake, and stay stable while they wait. `tx_last` is high only on the final byte of a descriptor whose command bit 0 (end of packet) is set. Descriptors without that bit are joined to the ones that follow.
- R6: Head moves forward by one after each finished descriptor. It wraps to 0 at ring size / 16.
- R7: A descriptor with a byte count of 0 sends no bytes. It still finishes and still follows the write-back rules.
- R8: A finished descriptor has 0x01 written to its byte 12 if its command bit 3 (report status) is set or descriptor control bit 24 (all-descriptor mode) is set. No other descriptor is written.
- R9: Write-backs are held until a batch has built up. A batch is flushed when the number of pending write-backs reaches descriptor control bits 21:16 (a value of 0 counts as 1), or when head equals tail, or when ring size / 16 − 1 descriptors have finished since the last flush. A flush comes before the next descriptor fetch.
- R10: Cause bit 0 is set by each status write-back. Cause bit 1 is set when a finished descriptor brings head equal to tail. Reading address 7 clears the register, but an event in the same cycle as that read stays set.
- R11: A tail write to an idle engine that is enabled and has work raises `mem_req` one cycle after the write is taken.
- R12: While transmit control bit 0 is clear, no descriptor fetch is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after `reg_rd` |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 64 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_ack | input | 1 | Memory acknowledge, one cycle per request |
| mem_rdata | input | 8 | Memory read byte, valid with `mem_ack` |
| tx_valid | output | 1 | Output byte valid |
| tx_data | output | 8 | Output byte |
| tx_last | output | 1 | Final byte of a packet |
| tx_ready | input | 1 | Downstream accepts the byte |

## Verification
A status write-back or a ring-empty event can set a cause bit in the same cycle that software reads the cause register and clears it. To provoke this, the bench reads the cause register every cycle while a run with per-descriptor flushes is in progress, so every set lands on a clearing read. It judges the result by counting the reads that return bit 0 and bit 1. These counts must equal the number of status writes and ring-empty events, which shows that no event was lost to the clear.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam int ADDR_W = 64;

  // register word addresses
  localparam logic [2:0] RA_BASE_LO = 3'd0;
  localparam logic [2:0] RA_BASE_HI = 3'd1;
  localparam logic [2:0] RA_RING_SZ = 3'd2;
  localparam logic [2:0] RA_HEAD    = 3'd3;
  localparam logic [2:0] RA_TAIL    = 3'd4;
  localparam logic [2:0] RA_TX_CTL  = 3'd5;
  localparam logic [2:0] RA_DSC_CTL = 3'd6;
  localparam logic [2:0] RA_CAUSE   = 3'd7;

  // descriptor byte offsets and command bits
  localparam logic [3:0] DB_LEN_LO = 4'd8;
  localparam logic [3:0] DB_LEN_HI = 4'd9;
  localparam logic [3:0] DB_CMD    = 4'd11;
  localparam int         DB_STAT   = 12;
  localparam int         CB_EOP    = 0;
  localparam int         CB_RS     = 3;
  localparam logic [7:0] ST_DONE   = 8'h01;

  typedef enum logic [2:0] {
    S_IDLE, S_DESC, S_BUF, S_OUT, S_FLUSH
  } txr_state_e;
endpackage

// File: rtl/txr_regs.sv
module txr_regs
  import txr_pkg::*;
#(
  parameter int MAX_DESC = 256,
  parameter int IDX_W    = $clog2(MAX_DESC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [IDX_W-1:0]  head,
  input  logic              set_done,
  input  logic              set_empty,
  output logic [ADDR_W-1:0] base,
  output logic [IDX_W:0]    ring_ent,
  output logic [IDX_W-1:0]  tail,
  output logic              tx_en,
  output logic              all_wb,
  output logic [5:0]        wthresh
);
  localparam int MAX_BLK = MAX_DESC / 8;
  localparam int BLK_W   = $clog2(MAX_BLK) + 1;

  logic [BLK_W-1:0] ring_blk;
  logic [1:0]       cause;
  logic [24:0]      wr_blk;

  assign wr_blk   = reg_wdata[31:7];
  assign ring_ent = {ring_blk, 3'b000};

  always_ff @(posedge clk) begin
    if (rst) begin
      base     <= '0;
      ring_blk <= BLK_W'(1);
      tail     <= '0;
      tx_en    <= 1'b0;
      all_wb   <= 1'b0;
      wthresh  <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        RA_BASE_LO: base[31:0]  <= reg_wdata;
        RA_BASE_HI: base[63:32] <= reg_wdata;
        RA_RING_SZ: begin
          if (wr_blk == '0)                 ring_blk <= BLK_W'(1);
          else if (wr_blk > 25'(MAX_BLK))   ring_blk <= BLK_W'(MAX_BLK);
          else                              ring_blk <= wr_blk[BLK_W-1:0];
        end
        RA_TAIL:    tail <= reg_wdata[IDX_W-1:0];
        RA_TX_CTL:  tx_en <= reg_wdata[0];
        RA_DSC_CTL: begin
          all_wb  <= reg_wdata[24];
          wthresh <= reg_wdata[21:16];
        end
        default: ;
      endcase
    end
  end

  // sticky cause bits; a read clears them but same-cycle events survive
  always_ff @(posedge clk) begin
    if (rst) begin
      cause <= '0;
    end else if (reg_rd && reg_addr == RA_CAUSE) begin
      cause <= {set_empty, set_done};
    end else begin
      cause <= cause | {set_empty, set_done};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        RA_BASE_LO: reg_rdata <= base[31:0];
        RA_BASE_HI: reg_rdata <= base[63:32];
        RA_RING_SZ: reg_rdata <= 32'(ring_blk) << 7;
        RA_HEAD:    reg_rdata <= 32'(head);
        RA_TAIL:    reg_rdata <= 32'(tail);
        RA_TX_CTL:  reg_rdata <= {31'b0, tx_en};
        RA_DSC_CTL: reg_rdata <= {7'b0, all_wb, 2'b0, wthresh, 16'b0};
        default:    reg_rdata <= {30'b0, cause};
      endcase
    end
  end
endmodule

// File: rtl/txr_engine.sv
module txr_engine
  import txr_pkg::*;
#(
  parameter int MAX_DESC = 256,
  parameter int IDX_W    = $clog2(MAX_DESC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] base,
  input  logic [IDX_W:0]    ring_ent,
  input  logic [IDX_W-1:0]  tail,
  input  logic              tx_en,
  input  logic              all_wb,
  input  logic [5:0]        wthresh,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic              mem_ack,
  input  logic [7:0]        mem_rdata,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  input  logic              tx_ready,
  output logic [IDX_W-1:0]  head,
  output logic              set_done,
  output logic              set_empty
);
  localparam int CW = IDX_W + 1;

  txr_state_e        state;
  logic [3:0]        k;
  logic [ADDR_W-1:0] buf_addr;
  logic [15:0]       len, off;
  logic              eop_q, rs_q;
  logic [MAX_DESC-1:0] need_wb;
  logic [CW-1:0]     pend_cnt, done_cnt, fl_cnt;
  logic [IDX_W-1:0]  fl_idx, wb_ptr;
  logic              fin, wants, flush_go;
  logic [CW-1:0]     thr;

  function automatic logic [IDX_W-1:0] nxt(input logic [IDX_W-1:0] i);
    return ({1'b0, i} + CW'(1) == ring_ent) ? '0 : i + IDX_W'(1);
  endfunction

  function automatic logic [ADDR_W-1:0] slot_addr(input logic [IDX_W-1:0] i);
    return base + ADDR_W'({i, 4'b0000});
  endfunction

  always_comb begin
    fin = (state == S_DESC && mem_ack && k == DB_CMD && len == '0) ||
          (state == S_OUT && tx_ready && off == len - 16'd1);
    wants = all_wb | ((state == S_DESC) ? mem_rdata[CB_RS] : rs_q);
    thr = (wthresh == '0) ? CW'(1) : CW'(wthresh);
    flush_go = (pend_cnt != '0 && (head == tail || pend_cnt >= thr)) ||
               (done_cnt != '0 && done_cnt >= ring_ent - CW'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE; k <= '0; buf_addr <= '0; len <= '0; off <= '0;
      eop_q <= 1'b0; rs_q <= 1'b0; need_wb <= '0;
      pend_cnt <= '0; done_cnt <= '0; fl_cnt <= '0; fl_idx <= '0; wb_ptr <= '0;
      mem_req <= 1'b0; mem_we <= 1'b0; mem_addr <= '0; mem_wdata <= '0;
      tx_valid <= 1'b0; tx_data <= '0; tx_last <= 1'b0;
      head <= '0; set_done <= 1'b0; set_empty <= 1'b0;
    end else begin
      set_done  <= 1'b0;
      set_empty <= 1'b0;
      case (state)
        S_IDLE: begin
          if (flush_go) begin
            state  <= S_FLUSH;
            fl_idx <= wb_ptr;
            fl_cnt <= done_cnt;
          end else if (tx_en && head != tail) begin
            state    <= S_DESC;
            k        <= '0;
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= slot_addr(head);
          end
        end
        S_DESC: if (mem_ack) begin
          if (k < 4'd8)          buf_addr[k[2:0]*8 +: 8] <= mem_rdata;
          else if (k == DB_LEN_LO) len[7:0]  <= mem_rdata;
          else if (k == DB_LEN_HI) len[15:8] <= mem_rdata;
          if (k == DB_CMD) begin
            eop_q <= mem_rdata[CB_EOP];
            rs_q  <= mem_rdata[CB_RS];
            if (len == '0) begin
              mem_req <= 1'b0;
              state   <= S_IDLE;
            end else begin
              off      <= '0;
              mem_addr <= buf_addr;
              state    <= S_BUF;
            end
          end else begin
            k        <= k + 4'd1;
            mem_addr <= mem_addr + 64'd1;
          end
        end
        S_BUF: if (mem_ack) begin
          mem_req  <= 1'b0;
          tx_valid <= 1'b1;
          tx_data  <= mem_rdata;
          tx_last  <= eop_q && (off == len - 16'd1);
          state    <= S_OUT;
        end
        S_OUT: if (tx_ready) begin
          tx_valid <= 1'b0;
          tx_last  <= 1'b0;
          if (off == len - 16'd1) begin
            state <= S_IDLE;
          end else begin
            off      <= off + 16'd1;
            mem_req  <= 1'b1;
            mem_addr <= buf_addr + 64'(off) + 64'd1;
            state    <= S_BUF;
          end
        end
        S_FLUSH: begin
          if (fl_cnt == '0) begin
            pend_cnt <= '0;
            done_cnt <= '0;
            wb_ptr   <= fl_idx;
            state    <= S_IDLE;
          end else if (need_wb[fl_idx]) begin
            if (!mem_req) begin
              mem_req   <= 1'b1;
              mem_we    <= 1'b1;
              mem_addr  <= slot_addr(fl_idx) + 64'(DB_STAT);
              mem_wdata <= ST_DONE;
            end else if (mem_ack) begin
              mem_req         <= 1'b0;
              mem_we          <= 1'b0;
              need_wb[fl_idx] <= 1'b0;
              set_done        <= 1'b1;
              fl_idx          <= nxt(fl_idx);
              fl_cnt          <= fl_cnt - CW'(1);
            end
          end else begin
            fl_idx <= nxt(fl_idx);
            fl_cnt <= fl_cnt - CW'(1);
          end
        end
        default: state <= S_IDLE;
      endcase
      if (fin) begin
        head          <= nxt(head);
        need_wb[head] <= wants;
        done_cnt      <= done_cnt + CW'(1);
        if (wants) pend_cnt <= pend_cnt + CW'(1);
        set_empty     <= (nxt(head) == tail);
      end
    end
  end
endmodule

// File: rtl/tx_ring_engine.sv
module tx_ring_engine
  import txr_pkg::*;
#(
  parameter int MAX_DESC = 256
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [63:0] mem_addr,
  output logic [7:0]  mem_wdata,
  input  logic        mem_ack,
  input  logic [7:0]  mem_rdata,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  output logic        tx_last,
  input  logic        tx_ready
);
  localparam int IDX_W = $clog2(MAX_DESC);

  logic [ADDR_W-1:0] base_w;
  logic [IDX_W:0]    ring_ent_w;
  logic [IDX_W-1:0]  tail_w, head_w;
  logic              en_w, all_wb_w, sdone_w, sempty_w;
  logic [5:0]        wthr_w;

  txr_regs #(.MAX_DESC(MAX_DESC), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .head(head_w), .set_done(sdone_w), .set_empty(sempty_w),
    .base(base_w), .ring_ent(ring_ent_w), .tail(tail_w), .tx_en(en_w),
    .all_wb(all_wb_w), .wthresh(wthr_w)
  );

  txr_engine #(.MAX_DESC(MAX_DESC), .IDX_W(IDX_W)) u_eng (
    .clk(clk), .rst(rst), .base(base_w), .ring_ent(ring_ent_w),
    .tail(tail_w), .tx_en(en_w), .all_wb(all_wb_w), .wthresh(wthr_w),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
    .tx_ready(tx_ready), .head(head_w), .set_done(sdone_w),
    .set_empty(sempty_w)
  );
endmodule

// File: rtl/txr_chk.sv
module txr_chk #(
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic             tx_last,
  input logic [7:0]       tx_data,
  input logic             mem_req,
  input logic             mem_we,
  input logic             mem_ack,
  input logic [63:0]      mem_addr,
  input logic [7:0]       mem_wdata,
  input logic [IDX_W-1:0] head,
  input logic [3:0]       base_lo
);
  p_last_needs_valid_r5: assert property (@(posedge clk) disable iff (rst)
    tx_last |-> tx_valid);

  p_out_hold_r5: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

  p_req_hold_r3: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  p_status_write_r8: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we |-> mem_wdata == 8'h01 && mem_addr[3:0] == base_lo + 4'hC);

  p_head_step_r6: assert property (@(posedge clk) disable iff (rst)
    head != $past(head) |-> (head == '0 || head == IDX_W'($past(head) + 1'b1)));
endmodule

bind tx_ring_engine txr_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_last(tx_last), .tx_data(tx_data), .mem_req(mem_req), .mem_we(mem_we),
  .mem_ack(mem_ack), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .head(head_w), .base_lo(base_w[3:0])
);

// File: tb/tx_ring_engine_tb.sv
`timescale 1ns/1ps
module tx_ring_engine_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we, mem_ack;
  logic [63:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        tx_valid, tx_last, tx_ready;
  logic [7:0]  tx_data;

  always #4 clk = ~clk;

  tx_ring_engine u_dut (.*);

  logic [7:0] memb [4096];
  logic [8:0] got_q[$], exp_q[$];
  int wr_got[$], wr_exp[$], wr_at[$];
  int checks = 0, errors = 0, stream_cnt = 0, rd_cnt = 0, hi_bad = 0;
  int fill = 0, tail_sw = 0, dw_cnt = 0, qe_cnt = 0;
  bit rdy_all = 0, cur_gran = 0, done_flag = 0;
  logic [31:0] rv;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr_reg(logic [2:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd_reg(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic cfg(bit gran, int wthr);
    cur_gran = gran;
    wr_reg(3'd6, {7'b0, gran, 2'b0, 6'(wthr), 16'b0});
  endtask

  task automatic add(int len, logic [7:0] cmd);
    int d, b;
    logic [7:0] v;
    d = 12'h100 + fill * 16;
    b = 12'h400 + fill * 64;
    for (int i = 0; i < 16; i++) memb[d + i] = 8'($urandom);
    memb[d] = 8'(b); memb[d+1] = 8'(b >> 8); memb[d+2] = 0; memb[d+3] = 0;
    memb[d+4] = 8'hA5; memb[d+5] = 0; memb[d+6] = 0; memb[d+7] = 0;
    memb[d+8] = 8'(len); memb[d+9] = 0; memb[d+11] = cmd; memb[d+12] = 0;
    for (int i = 0; i < len; i++) begin
      v = 8'($urandom);
      memb[b + i] = v;
      exp_q.push_back({cmd[0] && (i == len - 1), v});
    end
    if (cur_gran || cmd[3]) wr_exp.push_back(fill);
    fill = (fill + 1) % 8;
  endtask

  task automatic go();
    tail_sw = fill;
    wr_reg(3'd4, 32'(tail_sw));
  endtask

  task automatic settle();
    repeat (1500) @(negedge clk);
  endtask

  task automatic cmp_all(string req);
    bit ok;
    ok = (got_q.size() == exp_q.size());
    if (ok) foreach (exp_q[i]) if (got_q[i] != exp_q[i]) ok = 0;
    chk(ok, req, "stream bytes/last", got_q.size(), exp_q.size());
    ok = (wr_got.size() == wr_exp.size());
    if (ok) foreach (wr_exp[i]) if (wr_got[i] != wr_exp[i]) ok = 0;
    chk(ok, "R8", "status write slots", wr_got.size(), wr_exp.size());
    rd_reg(3'd3, rv);
    chk(rv == 32'(tail_sw), "R6", "head after run", rv, tail_sw);
    got_q.delete(); exp_q.delete(); wr_got.delete(); wr_exp.delete(); wr_at.delete();
  endtask

  // memory responder and stream sink, all at the falling edge
  initial begin
    int a;
    tx_ready = 0; mem_ack = 0; mem_rdata = 0;
    forever begin
      @(negedge clk);
      tx_ready = rdy_all ? 1'b1 : ($urandom % 3 != 0);
      if (tx_valid && tx_ready) begin
        got_q.push_back({tx_last, tx_data});
        stream_cnt++;
      end
      if (mem_req && ($urandom % 4 != 0)) begin
        mem_ack = 1;
        a = int'(mem_addr[11:0]);
        if (mem_addr[63:32] != 32'hA5) hi_bad++;
        if (mem_we) begin
          memb[a] = mem_wdata;
          wr_got.push_back((a - 12'h10C) >> 4);
          wr_at.push_back(stream_cnt);
        end else begin
          mem_rdata = memb[a];
          rd_cnt++;
        end
      end else mem_ack = 0;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      chk(0, "ALL", "watchdog expired", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    foreach (memb[i]) memb[i] = 0;
    repeat (5) @(negedge clk);
    rst = 0;

    // R1 reset state
    chk(tx_valid == 0 && mem_req == 0, "R1", "outputs idle", {tx_valid, mem_req}, 0);
    rd_reg(3'd3, rv); chk(rv == 0, "R1", "head", rv, 0);
    rd_reg(3'd4, rv); chk(rv == 0, "R1", "tail", rv, 0);
    rd_reg(3'd7, rv); chk(rv == 0, "R1", "cause", rv, 0);
    rd_reg(3'd2, rv); chk(rv == 128, "R1", "ring size", rv, 128);

    // R2 ring size rounding and clamping
    wr_reg(3'd2, 200);          rd_reg(3'd2, rv); chk(rv == 128, "R2", "round 200", rv, 128);
    wr_reg(3'd2, 5);            rd_reg(3'd2, rv); chk(rv == 128, "R2", "min", rv, 128);
    wr_reg(3'd2, 32'h0010_0000); rd_reg(3'd2, rv); chk(rv == 4096, "R2", "max", rv, 4096);
    wr_reg(3'd2, 300);          rd_reg(3'd2, rv); chk(rv == 256, "R2", "round 300", rv, 256);
    wr_reg(3'd2, 128);

    wr_reg(3'd0, 32'h100);
    wr_reg(3'd1, 32'hA5);

    // R12 disabled engine fetches nothing
    cfg(0, 0);
    add(3, 8'h08); add(2, 8'h01);
    go();
    repeat (100) @(negedge clk);
    chk(rd_cnt == 0 && got_q.size() == 0, "R12", "reads while disabled", rd_cnt, 0);
    rd_reg(3'd3, rv); chk(rv == 0, "R12", "head while disabled", rv, 0);

    // R3/R5 enable starts the queued work; first packet spans two descriptors
    wr_reg(3'd5, 1);
    settle();
    cmp_all("R3");

    // R4/R5 constrained random batches with wrap-around
    for (int b = 0; b < 6; b++) begin
      int n;
      cfg(b % 2, b % 3);
      n = 1 + $urandom % 7;
      for (int j = 0; j < n; j++)
        add($urandom % 7, {4'($urandom) & 4'b1100, $urandom % 2 == 0, 2'($urandom), (j == n - 1) || ($urandom % 2 == 0)});
      go();
      settle();
      cmp_all("R5");
    end

    // R7 zero-length descriptors still complete and report
    cfg(0, 1);
    add(0, 8'h09); add(3, 8'h01); add(0, 8'h09);
    go(); settle();
    cmp_all("R7");

    // R9 batching: threshold 3 in all-descriptor mode, 4 bytes each
    rdy_all = 1; stream_cnt = 0;
    cfg(1, 3);
    for (int j = 0; j < 5; j++) add(4, 8'h01);
    go(); settle();
    chk(wr_at.size() == 5 && wr_at[0] == 12 && wr_at[2] == 12 && wr_at[3] == 20 && wr_at[4] == 20,
        "R9", "flush points", wr_at.size() > 0 ? wr_at[0] : -1, 12);
    cmp_all("R9");
    rdy_all = 0;

    // R10 cause read every cycle while events arrive
    cfg(1, 1);
    rd_reg(3'd7, rv);
    for (int j = 0; j < 4; j++) add(2, 8'h01);
    go();
    reg_addr = 3'd7; reg_rd = 1;
    repeat (800) begin
      @(negedge clk);
      if (reg_rdata[0]) dw_cnt++;
      if (reg_rdata[1]) qe_cnt++;
    end
    reg_rd = 0;
    @(negedge clk);
    if (reg_rdata[0]) dw_cnt++;
    if (reg_rdata[1]) qe_cnt++;
    chk(dw_cnt == 4, "R10", "write-back cause count", dw_cnt, 4);
    chk(qe_cnt == 1, "R10", "ring-empty cause count", qe_cnt, 1);
    cmp_all("R10");

    // R11 restart the cycle after a tail write
    repeat (50) @(negedge clk);
    add(2, 8'h01);
    go();
    chk(mem_req == 0, "R11", "no request at write", mem_req, 0);
    @(negedge clk);
    chk(mem_req == 1 && mem_we == 0 && mem_addr[11:0] == 12'(12'h100 + ((tail_sw + 7) % 8) * 16),
        "R11", "descriptor request", mem_addr[11:0], 12'h100 + ((tail_sw + 7) % 8) * 16);
    settle();
    cmp_all("R11");

    chk(hi_bad == 0, "R4", "upper address word", hi_bad, 0);

    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule